// File: doc/BRIEF.md
# Vector Bit Permute Unit

This unit applies one of three mask-driven bit permutations to every element of a packed vector. A data vector and a mask vector of equal width enter together. The vector is split into elements of 8, 16, 32 or 64 bits, and each element is processed on its own.

- **Extract** packs the data bits picked out by the mask into the low end of the element.
- **Deposit** spreads the low data bits out into the positions picked out by the mask.
- **Group** packs the picked bits at the bottom and the remaining bits directly above them.

The operation and the element size come from a 32-bit instruction word, which a small decoder checks and splits into fields. A feature-enable input decides whether these operations are legal at all. An illegal request does not execute. Instead it produces a zero result with an illegal flag.

Requests enter through a valid/ready handshake, at a rate of one per cycle. The result comes from a register, one cycle after acceptance. It is held there until the consumer takes it.

Top module: `bitperm_unit`

## Requirements
- R1: Extract (operation field 00): within each element, the data bits whose mask bit is 1 are taken in order from the least significant bit upward. They are written to consecutive result bits starting at bit 0. All higher result bits are 0.
- R2: Deposit (operation field 01): within each element, the result positions whose mask bit is 1 are visited from the least significant bit upward. Each receives the next data bit, starting at data bit 0. Positions whose mask bit is 0 read 0.
- R3: Group (operation field 10): within each element, the mask-1 data bits sit contiguously at the bottom of the result in their original order. The mask-0 data bits follow directly above them, also in their original order.
- R4: The element size field, instruction bits [23:22], selects 8, 16, 32 or 64 bits for the codes 0, 1, 2 and 3. No element's result depends on the data or mask bits of another element.
- R5: An instruction is recognised only when all of the following hold: bits [31:24] equal 8'h45, bit 21 is 0, and bits [15:12] equal 4'b1011. In that case, bits [11:10] select the operation.
- R6: An operation field of 11 sets the illegal flag and gives an all-zero result.
- R7: With featureEn low, every operation sets the illegal flag and gives an all-zero result.
- R8: A word that fails the fixed-field check of R5 sets the illegal flag and gives an all-zero result.
- R9: inReady is high whenever no result is waiting or outReady is high. A request accepted on a clock edge appears with outValid high after that edge. While outValid is high and outReady is low, the result and flag stay unchanged.
- R10: With an all-ones mask, extract and deposit return the data unchanged. With an all-zeros mask, extract and deposit return zero and group returns the data unchanged.
- R11: After reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featureEn | input | 1 | Bit-permute operations are legal when high |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be accepted this cycle |
| instrWord | input | 32 | Instruction word holding the operation and element size |
| dataVec | input | VEC_W | Data source vector |
| maskVec | input | VEC_W | Mask source vector |
| outValid | output | 1 | Result register holds an unconsumed result |
| outReady | input | 1 | Consumer takes the result this cycle |
| outResult | output | VEC_W | Permuted vector |
| outIllegal | output | 1 | Request was illegal; result is zero |

## Verification
The bench builds the unit with VEC_W = 128. At that width a vector holds sixteen byte elements but only two 64-bit elements, so every size has at least two elements whose results must stay apart. Each result is compared with a bit-serial model over table-driven and random data and masks at all four sizes. Further checks cover the all-ones and all-zeros mask identities, each illegal path, and a stalled consumer that overlaps acceptance with a drain.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

  typedef enum logic [1:0] {
    OP_EXTRACT = 2'b00,
    OP_DEPOSIT = 2'b01,
    OP_GROUP   = 2'b10,
    OP_RSVD    = 2'b11
  } permOp_e;

  localparam int NUM_SIZES = 4;
  localparam int MAX_ELEM_W = 64;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    illegal;
    permOp_e op;
    logic [1:0] sizeSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/bitperm_elem.sv
module bitperm_elem
  import bitperm_pkg::*;
#(
  parameter int EW = 8
) (
  input  permOp_e        op,
  input  logic [EW-1:0]  d,
  input  logic [EW-1:0]  m,
  output logic [EW-1:0]  r
);
  localparam int IW = $clog2(EW);

  logic [EW-1:0] lo;
  logic [EW-1:0] hi;
  int nSel;
  int nUns;

  always_comb begin
    lo = '0;
    hi = '0;
    nSel = 0;
    nUns = 0;
    for (int i = 0; i < EW; i++) begin
      case (op)
        OP_EXTRACT: begin
          if (m[i]) begin
            lo[nSel[IW-1:0]] = d[i];
            nSel = nSel + 1;
          end
        end
        OP_DEPOSIT: begin
          if (m[i]) begin
            lo[i] = d[nSel[IW-1:0]];
            nSel = nSel + 1;
          end
        end
        OP_GROUP: begin
          if (m[i]) begin
            lo[nSel[IW-1:0]] = d[i];
            nSel = nSel + 1;
          end else begin
            hi[nUns[IW-1:0]] = d[i];
            nUns = nUns + 1;
          end
        end
        default: ;
      endcase
    end
    if (op == OP_GROUP) r = lo | (hi << nSel);
    else                r = lo;
  end

endmodule

// File: rtl/bitperm_ctrl.sv
module bitperm_ctrl
  import bitperm_pkg::*;
(
  input  logic         featureEn,
  input  logic         inValid,
  input  logic [31:0]  instrWord,
  input  logic         outValidQ,
  input  logic         outReady,
  output logic         inReady,
  output ctrlStrobes_t strobes
);
  localparam logic [7:0] PREFIX_HI = 8'h45;
  localparam logic [3:0] GROUP_SEL = 4'b1011;

  logic prefixOk;
  logic opOk;
  logic [1:0] opBits;
  logic unusedRegFields;

  assign unusedRegFields = ^{instrWord[20:16], instrWord[9:0]};

  assign opBits   = instrWord[11:10];
  assign prefixOk = (instrWord[31:24] == PREFIX_HI) && !instrWord[21]
                    && (instrWord[15:12] == GROUP_SEL);
  assign opOk     = (opBits != 2'b11);

  assign inReady = !outValidQ || outReady;

  always_comb begin
    strobes.load    = inValid && inReady;
    strobes.illegal = !(featureEn && prefixOk && opOk);
    strobes.op      = permOp_e'(opBits);
    strobes.sizeSel = instrWord[23:22];
  end

endmodule

// File: rtl/bitperm_dpath.sv
module bitperm_dpath
  import bitperm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [VEC_W-1:0]  dataVec,
  input  logic [VEC_W-1:0]  maskVec,
  input  logic              outReady,
  output logic              outValidQ,
  output logic [VEC_W-1:0]  resultQ,
  output logic              illegalQ
);
  logic [VEC_W-1:0] resBySize [NUM_SIZES];
  logic [VEC_W-1:0] resSel;

  for (genvar sz = 0; sz < NUM_SIZES; sz++) begin : g_size
    localparam int EW = 8 << sz;
    localparam int NE = VEC_W / EW;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      bitperm_elem #(.EW(EW)) u_elem (
        .op (strobes.op),
        .d  (dataVec[e*EW +: EW]),
        .m  (maskVec[e*EW +: EW]),
        .r  (resBySize[sz][e*EW +: EW])
      );
    end
  end

  assign resSel = resBySize[strobes.sizeSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      resultQ   <= '0;
      illegalQ  <= 1'b0;
    end else if (strobes.load) begin
      outValidQ <= 1'b1;
      resultQ   <= strobes.illegal ? '0 : resSel;
      illegalQ  <= strobes.illegal;
    end else if (outReady) begin
      outValidQ <= 1'b0;
    end
  end

endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              featureEn,
  input  logic              inValid,
  output logic              inReady,
  input  logic [31:0]       instrWord,
  input  logic [VEC_W-1:0]  dataVec,
  input  logic [VEC_W-1:0]  maskVec,
  output logic              outValid,
  input  logic              outReady,
  output logic [VEC_W-1:0]  outResult,
  output logic              outIllegal
);
  ctrlStrobes_t strobes;

  bitperm_ctrl u_ctrl (
    .featureEn (featureEn),
    .inValid   (inValid),
    .instrWord (instrWord),
    .outValidQ (outValid),
    .outReady  (outReady),
    .inReady   (inReady),
    .strobes   (strobes)
  );

  bitperm_dpath #(.VEC_W(VEC_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataVec   (dataVec),
    .maskVec   (maskVec),
    .outReady  (outReady),
    .outValidQ (outValid),
    .resultQ   (outResult),
    .illegalQ  (outIllegal)
  );

endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              featureEn,
  input logic              inValid,
  input logic              inReady,
  input logic [31:0]       instrWord,
  input logic [VEC_W-1:0]  dataVec,
  input logic [VEC_W-1:0]  maskVec,
  input logic              outValid,
  input logic              outReady,
  input logic [VEC_W-1:0]  outResult,
  input logic              outIllegal
);
  logic acc;
  logic wordOk;
  assign acc    = inValid && inReady;
  assign wordOk = featureEn && (instrWord[31:24] == 8'h45) && !instrWord[21]
                  && (instrWord[15:12] == 4'b1011);

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  assert_accept_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> outValid);

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !acc) |=> (outValid && $stable(outResult) && $stable(outIllegal)));

  assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIllegal) |-> (outResult == '0));

  assert_rsvd_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    (acc && instrWord[11:10] == 2'b11) |=> outIllegal);

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !featureEn) |=> (outIllegal && outResult == '0));

  assert_bad_prefix_R8: assert property (@(posedge clk) disable iff (!rstN)
    (acc && instrWord[31:24] != 8'h45) |=> outIllegal);

  assert_extract_ones_R10: assert property (@(posedge clk) disable iff (!rstN)
    (acc && wordOk && instrWord[11:10] == 2'b00 && (&maskVec))
      |=> (outResult == $past(dataVec)));

  assert_group_zeros_R10: assert property (@(posedge clk) disable iff (!rstN)
    (acc && wordOk && instrWord[11:10] == 2'b10 && maskVec == '0)
      |=> (outResult == $past(dataVec)));

endmodule

bind bitperm_unit bitperm_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .featureEn(featureEn), .inValid(inValid),
  .inReady(inReady), .instrWord(instrWord), .dataVec(dataVec),
  .maskVec(maskVec), .outValid(outValid), .outReady(outReady),
  .outResult(outResult), .outIllegal(outIllegal)
);

// File: tb/sim_bitperm_unit.sv
module sim_bitperm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic featureEn = 1'b1;
  logic inValid = 1'b0;
  logic inReady;
  logic [31:0] instrWord = '0;
  logic [VW-1:0] dataVec = '0;
  logic [VW-1:0] maskVec = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [VW-1:0] outResult;
  logic outIllegal;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitperm_unit #(.VEC_W(VW)) u0 (
    .clk(clk), .rstN(rstN), .featureEn(featureEn), .inValid(inValid),
    .inReady(inReady), .instrWord(instrWord), .dataVec(dataVec),
    .maskVec(maskVec), .outValid(outValid), .outReady(outReady),
    .outResult(outResult), .outIllegal(outIllegal)
  );

  // {op, size, data64, mask64}; vectors replicate the 64-bit pattern
  localparam int NT = 8;
  localparam logic [131:0] TABLE [NT] = '{
    {2'd0, 2'd0, 64'hA5A5_3C3C_0F0F_FF00, 64'hF0F0_AAAA_5555_0FF0},
    {2'd1, 2'd1, 64'h0123_4567_89AB_CDEF, 64'hFF00_F0F0_8421_1248},
    {2'd2, 2'd2, 64'hDEAD_BEEF_CAFE_F00D, 64'h0F0F_F0F0_3333_CCCC},
    {2'd0, 2'd3, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001},
    {2'd1, 2'd3, 64'h0000_0000_0000_00FF, 64'hF0F0_0000_0000_000F},
    {2'd2, 2'd0, 64'h1122_3344_5566_7788, 64'h8181_4242_2424_1818},
    {2'd0, 2'd1, 64'hFFFF_0000_FFFF_0000, 64'hAAAA_AAAA_5555_5555},
    {2'd3, 2'd2, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000}
  };

  function automatic logic [31:0] mkInstr(input logic [1:0] op, input logic [1:0] sz);
    return {8'h45, sz, 1'b0, 5'd3, 4'b1011, op, 5'd1, 5'd2};
  endfunction

  // Bit-serial reference
  function automatic logic [VW-1:0] model(input logic [1:0] op, input logic [1:0] sz,
                                          input logic [VW-1:0] d, input logic [VW-1:0] m);
    logic [VW-1:0] r = '0;
    int w = 8 << sz;
    if (op == 2'd3) return '0;
    for (int base = 0; base < VW; base += w) begin
      int k = 0;
      if (op == 2'd0) begin
        for (int b = 0; b < w; b++) if (m[base+b]) begin r[base+k] = d[base+b]; k++; end
      end else if (op == 2'd1) begin
        for (int b = 0; b < w; b++) if (m[base+b]) begin r[base+b] = d[base+k]; k++; end
      end else begin
        for (int b = 0; b < w; b++) if (m[base+b]) begin r[base+k] = d[base+b]; k++; end
        for (int b = 0; b < w; b++) if (!m[base+b]) begin r[base+k] = d[base+b]; k++; end
      end
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [31:0] ins, input logic fe,
                       input logic [VW-1:0] d, input logic [VW-1:0] m,
                       input logic [VW-1:0] expR, input logic expI, input string tag);
    @(negedge clk);
    instrWord = ins; featureEn = fe; dataVec = d; maskVec = m; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1 && outResult === expR && outIllegal === expI,
          tag, outResult, expR);
  endtask

  function automatic string opTag(input logic [1:0] op);
    case (op)
      2'd0: return "R1 extract";
      2'd1: return "R2 deposit";
      2'd2: return "R3 group";
      default: return "R6 reserved op";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [VW-1:0] d, m, rA, rB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(outValid === 1'b0 && inReady === 1'b1, "R11 reset", {126'b0, outValid, inReady}, 128'd1);

    // Table walk (R1 R2 R3 R4 R5 R6)
    for (int t = 0; t < NT; t++) begin
      logic [1:0] op = TABLE[t][131:130];
      logic [1:0] sz = TABLE[t][129:128];
      d = {2{TABLE[t][127:64]}};
      m = {2{TABLE[t][63:0]}};
      runOp(mkInstr(op, sz), 1'b1, d, m, model(op, sz, d, m), op == 2'd3, opTag(op));
    end

    // Random at all sizes (R4 R5)
    for (int i = 0; i < 240; i++) begin
      logic [1:0] op = 2'($urandom_range(0, 2));
      logic [1:0] sz = 2'(i % 4);
      d = {$urandom, $urandom, $urandom, $urandom};
      m = {$urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 0) m = m & {$urandom, $urandom, $urandom, $urandom};
      runOp(mkInstr(op, sz), 1'b1, d, m, model(op, sz, d, m), 1'b0, "R4 random size/op");
    end

    // R4 lane independence: mask in element 0 only, all data ones
    for (int sz = 0; sz < 4; sz++) begin
      d = '1;
      m = 128'h1;
      runOp(mkInstr(2'd1, 2'(sz)), 1'b1, d, m, 128'h1, 1'b0, "R4 lane isolation");
    end

    // R10 corners
    d = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    for (int sz = 0; sz < 4; sz++) begin
      runOp(mkInstr(2'd0, 2'(sz)), 1'b1, d, '1, d, 1'b0, "R10 extract ones");
      runOp(mkInstr(2'd1, 2'(sz)), 1'b1, d, '1, d, 1'b0, "R10 deposit ones");
      runOp(mkInstr(2'd2, 2'(sz)), 1'b1, d, '0, d, 1'b0, "R10 group zeros");
      runOp(mkInstr(2'd0, 2'(sz)), 1'b1, d, '0, '0, 1'b0, "R10 extract zeros");
      runOp(mkInstr(2'd1, 2'(sz)), 1'b1, d, '0, '0, 1'b0, "R10 deposit zeros");
    end

    // R7 feature disabled
    for (int op = 0; op < 3; op++)
      runOp(mkInstr(2'(op), 2'd0), 1'b0, d, '1, '0, 1'b1, "R7 feature off");

    // R8 bad fixed fields
    runOp(mkInstr(2'd0, 2'd0) ^ 32'h0100_0000, 1'b1, d, '1, '0, 1'b1, "R8 bad prefix");
    runOp(mkInstr(2'd0, 2'd0) | 32'h0020_0000, 1'b1, d, '1, '0, 1'b1, "R8 bit21 set");
    runOp(mkInstr(2'd0, 2'd0) ^ 32'h0000_1000, 1'b1, d, '1, '0, 1'b1, "R8 bad group sel");
    runOp(mkInstr(2'd3, 2'd3), 1'b1, d, '1, '0, 1'b1, "R6 reserved op");

    // R9 stall and overlap
    rA = model(2'd2, 2'd1, d, 128'h00FF_F00F_1234_8001_FFFF_0000_AAAA_5555);
    rB = model(2'd0, 2'd2, ~d, 128'h00FF_F00F_1234_8001_FFFF_0000_AAAA_5555);
    @(negedge clk);
    outReady = 1'b0;
    instrWord = mkInstr(2'd2, 2'd1); featureEn = 1'b1; dataVec = d;
    maskVec = 128'h00FF_F00F_1234_8001_FFFF_0000_AAAA_5555; inValid = 1'b1;
    @(negedge clk);
    check(outValid === 1'b1 && inReady === 1'b0, "R9 stall ready low",
          {126'b0, outValid, inReady}, 128'd2);
    instrWord = mkInstr(2'd0, 2'd2); dataVec = ~d;
    @(negedge clk);
    check(outValid === 1'b1 && outResult === rA, "R9 held result", outResult, rA);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1 && outResult === rB, "R9 overlap accept", outResult, rB);
    @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R9 drained",
          {126'b0, outValid, inReady}, 128'd1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule